// File: doc/BRIEF.md
# Copy Engine Channel Register File

This block holds the per-channel programming registers of a multi-channel copy engine. A bus front end presents one request at a time: read or write, a byte address, an access size in bytes and write data aligned to bit 0. The block strips off a fixed global region at the bottom of its address space. It picks the channel from the remaining address in 128-byte windows. It checks that the access width suits the addressed register, and one cycle later it returns a response with read data or an error flag.

On the channel side, the block drives each channel's control word, descriptor chain address and completion-record address. It strobes a command to the addressed channel. It takes back each channel's busy flag, its status word, its error-set bits and a request to set the interrupt-disable bit. The 64-bit address registers can be loaded whole or one 32-bit half at a time. Error bits are cleared by writing ones. The interrupt-disable bit in the control word follows its own write rule.

Top module: `ce_chan_regs`

## Requirements
- R1: For an address A at or above GLOBAL_BYTES, the channel is (A - GLOBAL_BYTES) / 128 and the register offset is (A - GLOBAL_BYTES) mod 128. An address below GLOBAL_BYTES, or a channel number of NUM_CH or more, gets an error response and changes no register.
- R2: Legal access sizes per offset: 0x00 control 2 bytes; 0x04 status 8; 0x0C chain address low 8 or 4; 0x10 chain address high 4; 0x14 command 1; 0x18 completion address low 8 or 4; 0x1C completion address high 4; 0x28 error 4. Any other size (including sizes other than 1, 2, 4 or 8) or any other offset gets an error response and changes no register.
- R3: Every request cycle is followed in the next cycle by rsp_valid_o high. rsp_rdata_o is the register value zero-extended to 64 bits, and it is 0 for writes and for errored accesses.
- R4: Control is 16 bits. A write loads bits other than bit IDIS_BIT from the data. If the data has 1 at IDIS_BIT, that bit is cleared; if it has 0, the bit keeps its old value. A pulse on ch_idis_set_i sets it.
- R5: A status read returns ch_status_i bits 63:1 with bit 0 equal to NOT ch_busy_i of that channel. Writes to status are accepted and ignored.
- R6: An 8-byte write at 0x0C or 0x18 loads the whole 64-bit address. A 4-byte write there loads bits 31:0 and keeps bits 63:32. A 4-byte write at 0x10 or 0x1C loads bits 63:32 and keeps bits 31:0. A 4-byte read at the low word returns bits 31:0, and a read at the high word returns bits 63:32.
- R7: A legal command write stores the byte for readback, drives cmd_code_o with it, and raises cmd_pulse_o for that channel only, for exactly the one following cycle.
- R8: The 32-bit error register clears each bit written as 1. A bit set through ch_err_set_i in the same cycle stays set.
- R9: After reset all registers, rsp_valid_o, rsp_err_o and cmd_pulse_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 4 | Access size in bytes |
| req_wdata_i | input | 64 | Write data, aligned to bit 0 |
| rsp_valid_o | output | 1 | Response valid |
| rsp_err_o | output | 1 | Access rejected |
| rsp_rdata_o | output | 64 | Read data |
| ch_busy_i | input | NUM_CH | Channel busy flags |
| ch_status_i | input | 64*NUM_CH | Channel status words |
| ch_err_set_i | input | 32*NUM_CH | Error bits to set |
| ch_idis_set_i | input | NUM_CH | Set interrupt-disable bit |
| ctrl_o | output | 16*NUM_CH | Control words |
| chain_addr_o | output | 64*NUM_CH | Descriptor chain addresses |
| compl_addr_o | output | 64*NUM_CH | Completion record addresses |
| cmd_code_o | output | 8 | Last command byte written |
| cmd_pulse_o | output | NUM_CH | Command strobe per channel |

## Verification
The assertions check on every cycle that:
- each request gets a response in the next cycle;
- command strobes are at most one-hot and come only after a write;
- a rejected access leaves the address registers untouched;
- an illegal size is flagged;
- error bits never appear unless a channel set them.

Only the bench's sweeps can show the width table per offset, the half-word merge of the address registers, the interrupt-disable write rule, the status busy bit and the set-wins rule of the error register. It covers every channel, including one out of range, every word offset and sizes 0 to 9.

// File: rtl/ce_chan_regs.sv
module ce_chan_regs #(
  parameter int NUM_CH       = 4,
  parameter int ADDR_W       = 12,
  parameter int GLOBAL_BYTES = 128,
  parameter int IDIS_BIT     = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [3:0]             req_size_i,
  input  logic [63:0]            req_wdata_i,
  output logic                   rsp_valid_o,
  output logic                   rsp_err_o,
  output logic [63:0]            rsp_rdata_o,
  input  logic [NUM_CH-1:0]      ch_busy_i,
  input  logic [64*NUM_CH-1:0]   ch_status_i,
  input  logic [32*NUM_CH-1:0]   ch_err_set_i,
  input  logic [NUM_CH-1:0]      ch_idis_set_i,
  output logic [16*NUM_CH-1:0]   ctrl_o,
  output logic [64*NUM_CH-1:0]   chain_addr_o,
  output logic [64*NUM_CH-1:0]   compl_addr_o,
  output logic [7:0]             cmd_code_o,
  output logic [NUM_CH-1:0]      cmd_pulse_o
);
  localparam int CIW = ADDR_W - 7;

  localparam logic [6:0] OFF_CTRL = 7'h00, OFF_STAT = 7'h04, OFF_CHLO = 7'h0C,
                         OFF_CHHI = 7'h10, OFF_CMD  = 7'h14, OFF_CPLO = 7'h18,
                         OFF_CPHI = 7'h1C, OFF_ERR  = 7'h28;

  logic [ADDR_W-1:0] rel;
  logic [CIW-1:0]    ch_idx;
  logic [6:0]        off;
  logic              ch_ok, reg_ok, acc_ok, sz4, sz8;

  assign rel    = req_addr_i - ADDR_W'(GLOBAL_BYTES);
  assign ch_idx = rel[ADDR_W-1:7];
  assign off    = rel[6:0];
  assign ch_ok  = (req_addr_i >= ADDR_W'(GLOBAL_BYTES)) &&
                  ({1'b0, ch_idx} < (CIW+1)'(NUM_CH));
  assign sz4    = req_size_i == 4'd4;
  assign sz8    = req_size_i == 4'd8;

  always_comb begin
    case (off)
      OFF_CTRL:           reg_ok = req_size_i == 4'd2;
      OFF_STAT:           reg_ok = sz8;
      OFF_CHLO, OFF_CPLO: reg_ok = sz8 || sz4;
      OFF_CHHI, OFF_CPHI,
      OFF_ERR:            reg_ok = sz4;
      OFF_CMD:            reg_ok = req_size_i == 4'd1;
      default:            reg_ok = 1'b0;
    endcase
  end

  assign acc_ok = ch_ok && reg_ok;

  logic [15:0] ctrl_q  [NUM_CH];
  logic [63:0] chain_q [NUM_CH];
  logic [63:0] compl_q [NUM_CH];
  logic [7:0]  cmd_q   [NUM_CH];
  logic [31:0] err_q   [NUM_CH];
  logic [15:0] ctrl_n  [NUM_CH];
  logic [63:0] chain_n [NUM_CH];
  logic [63:0] compl_n [NUM_CH];
  logic [31:0] err_n   [NUM_CH];
  logic [NUM_CH-1:0] wr_hit;
  logic [31:0] err_flat [NUM_CH];

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      wr_hit[i]  = req_valid_i && req_write_i && acc_ok && (ch_idx == CIW'(i));
      ctrl_n[i]  = ctrl_q[i];
      chain_n[i] = chain_q[i];
      compl_n[i] = compl_q[i];
      err_n[i]   = err_q[i] & ~((wr_hit[i] && off == OFF_ERR) ? req_wdata_i[31:0] : 32'd0);
      if (wr_hit[i] && off == OFF_CTRL) begin
        ctrl_n[i] = req_wdata_i[15:0];
        ctrl_n[i][IDIS_BIT] = req_wdata_i[IDIS_BIT] ? 1'b0 : ctrl_q[i][IDIS_BIT];
      end
      if (ch_idis_set_i[i]) ctrl_n[i][IDIS_BIT] = 1'b1;
      if (wr_hit[i] && off == OFF_CHLO)
        chain_n[i] = sz8 ? req_wdata_i : {chain_q[i][63:32], req_wdata_i[31:0]};
      if (wr_hit[i] && off == OFF_CHHI)
        chain_n[i] = {req_wdata_i[31:0], chain_q[i][31:0]};
      if (wr_hit[i] && off == OFF_CPLO)
        compl_n[i] = sz8 ? req_wdata_i : {compl_q[i][63:32], req_wdata_i[31:0]};
      if (wr_hit[i] && off == OFF_CPHI)
        compl_n[i] = {req_wdata_i[31:0], compl_q[i][31:0]};
      err_n[i] = err_n[i] | ch_err_set_i[32*i +: 32];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (!rst_n) begin
        ctrl_q[i] <= '0; chain_q[i] <= '0; compl_q[i] <= '0;
        cmd_q[i] <= '0; err_q[i] <= '0;
      end else begin
        ctrl_q[i]  <= ctrl_n[i];
        chain_q[i] <= chain_n[i];
        compl_q[i] <= compl_n[i];
        err_q[i]   <= err_n[i];
        if (wr_hit[i] && off == OFF_CMD) cmd_q[i] <= req_wdata_i[7:0];
      end
    end
  end

  logic [63:0] rd;
  always_comb begin
    rd = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_idx == CIW'(i)) begin
        case (off)
          OFF_CTRL: rd = {48'd0, ctrl_q[i]};
          OFF_STAT: rd = {ch_status_i[64*i+1 +: 63], ~ch_busy_i[i]};
          OFF_CHLO: rd = sz8 ? chain_q[i] : {32'd0, chain_q[i][31:0]};
          OFF_CHHI: rd = {32'd0, chain_q[i][63:32]};
          OFF_CMD:  rd = {56'd0, cmd_q[i]};
          OFF_CPLO: rd = sz8 ? compl_q[i] : {32'd0, compl_q[i][31:0]};
          OFF_CPHI: rd = {32'd0, compl_q[i][63:32]};
          OFF_ERR:  rd = {32'd0, err_q[i]};
          default:  rd = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
      cmd_pulse_o <= '0;
      cmd_code_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && !acc_ok;
      rsp_rdata_o <= (req_valid_i && !req_write_i && acc_ok) ? rd : 64'd0;
      for (int i = 0; i < NUM_CH; i++)
        cmd_pulse_o[i] <= wr_hit[i] && off == OFF_CMD;
      if (|wr_hit && off == OFF_CMD) cmd_code_o <= req_wdata_i[7:0];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_out
    assign ctrl_o[16*g +: 16]       = ctrl_q[g];
    assign chain_addr_o[64*g +: 64] = chain_q[g];
    assign compl_addr_o[64*g +: 64] = compl_q[g];
    assign err_flat[g]              = err_q[g];

    // R8
    err_no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_flat[g] & ~$past(err_flat[g]) & ~$past(ch_err_set_i[32*g +: 32])) == 32'd0));
  end

  // R3
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o);

  // R7
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pulse_o));

  // R7
  cmd_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_pulse_o) |-> $past(req_valid_i && req_write_i));

  // R1
  bad_access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !acc_ok) |=> ($stable(chain_addr_o) && $stable(compl_addr_o)));

  // R2
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !(req_size_i inside {4'd1, 4'd2, 4'd4, 4'd8})) |=> rsp_err_o);
endmodule

// File: tb/ce_chan_regs_tb_top.sv
module ce_chan_regs_tb_top;
  localparam int NCH = 2;
  localparam int AW  = 10;
  localparam int GB  = 128;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_size = '0;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [NCH-1:0] busy = 2'b01;
  logic [64*NCH-1:0] stat;
  logic [32*NCH-1:0] err_set = '0;
  logic [NCH-1:0] idis_set = '0;
  logic [16*NCH-1:0] ctrl_o;
  logic [64*NCH-1:0] chain_o, compl_o;
  logic [7:0] cmd_code;
  logic [NCH-1:0] cmd_pulse;

  int total = 0, bad = 0;
  logic [15:0] m_ctrl [NCH];
  logic [63:0] m_chain [NCH], m_compl [NCH];
  logic [7:0]  m_cmd [NCH];
  logic [31:0] m_err [NCH];
  logic r_err, r_valid;
  logic [63:0] r_data;
  logic [NCH-1:0] r_pulse;
  logic [7:0] r_code;

  always #2 clk = ~clk;

  assign stat = {64'hDEAD_BEEF_0BAD_F00D, 64'h1234_5678_9ABC_DEF1};

  ce_chan_regs #(.NUM_CH(NCH), .ADDR_W(AW), .GLOBAL_BYTES(GB), .IDIS_BIT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .ch_busy_i(busy), .ch_status_i(stat), .ch_err_set_i(err_set),
    .ch_idis_set_i(idis_set), .ctrl_o(ctrl_o), .chain_addr_o(chain_o),
    .compl_addr_o(compl_o), .cmd_code_o(cmd_code), .cmd_pulse_o(cmd_pulse));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit legal(input int off, input int sz);
    case (off)
      'h00: return sz == 2;
      'h04: return sz == 8;
      'h0C, 'h18: return sz == 8 || sz == 4;
      'h10, 'h1C, 'h28: return sz == 4;
      'h14: return sz == 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] exp_rd(input int ch, input int off, input int sz);
    case (off)
      'h00: return {48'd0, m_ctrl[ch]};
      'h04: return {stat[64*ch+1 +: 63], ~busy[ch]};
      'h0C: return sz == 8 ? m_chain[ch] : {32'd0, m_chain[ch][31:0]};
      'h10: return {32'd0, m_chain[ch][63:32]};
      'h14: return {56'd0, m_cmd[ch]};
      'h18: return sz == 8 ? m_compl[ch] : {32'd0, m_compl[ch][31:0]};
      'h1C: return {32'd0, m_compl[ch][63:32]};
      'h28: return {32'd0, m_err[ch]};
      default: return 64'd0;
    endcase
  endfunction

  task automatic model_wr(input int ch, input int off, input int sz, input logic [63:0] d);
    case (off)
      'h00: m_ctrl[ch] = {d[15:1], d[0] ? 1'b0 : m_ctrl[ch][0]};
      'h0C: m_chain[ch] = sz == 8 ? d : {m_chain[ch][63:32], d[31:0]};
      'h10: m_chain[ch] = {d[31:0], m_chain[ch][31:0]};
      'h14: m_cmd[ch] = d[7:0];
      'h18: m_compl[ch] = sz == 8 ? d : {m_compl[ch][63:32], d[31:0]};
      'h1C: m_compl[ch] = {d[31:0], m_compl[ch][31:0]};
      'h28: m_err[ch] = m_err[ch] & ~d[31:0];
      default: ;
    endcase
  endtask

  task automatic acc(input bit w, input int addr, input int sz, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = AW'(addr); req_size = 4'(sz); req_wdata = d;
    @(posedge clk); #1;
    r_valid = rsp_valid; r_err = rsp_err; r_data = rsp_rdata; r_pulse = cmd_pulse; r_code = cmd_code;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic chk_outs(input int ch);
    chk("R4 ctrl_o", {48'd0, ctrl_o[16*ch +: 16]}, {48'd0, m_ctrl[ch]});
    chk("R6 chain_addr_o", chain_o[64*ch +: 64], m_chain[ch]);
    chk("R6 compl_addr_o", compl_o[64*ch +: 64], m_compl[ch]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_ctrl[c] = 0; m_chain[c] = 0; m_compl[c] = 0; m_cmd[c] = 0; m_err[c] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R9 cmd_pulse", {62'd0, cmd_pulse}, 64'd0);
    chk("R9 regs", {ctrl_o, chain_o[63:0]}, '0);
    @(negedge clk); rst_n = 1;

    // set interrupt-disable and all error bits from the channel side
    idis_set = '1; err_set = '1;
    @(negedge clk); idis_set = '0; err_set = '0;
    for (int c = 0; c < NCH; c++) begin m_ctrl[c][0] = 1; m_err[c] = '1; end

    // sweep: channels 0..2, offsets, sizes 0..9, plus global region
    for (int c = -1; c <= NCH; c++) begin
      for (int o = 0; o <= 'h2C; o += 4) begin
        for (int s = 0; s <= 9; s++) begin
          int a;
          bit ok;
          logic [63:0] d;
          logic [63:0] ep;
          a  = (c < 0) ? o : GB + c * 128 + o;
          ok = (c >= 0) && (c < NCH) && legal(o, s);
          d  = 64'hF0E1_D2C3_B4A5_9687 ^ (64'(c + 1) << 44) ^ (64'(o) << 16) ^ 64'(s * 37);
          acc(1, a, s, d);
          chk("R3 wr rsp_valid", {63'd0, r_valid}, 64'd1);
          chk("R1 R2 wr err", {63'd0, r_err}, {63'd0, !ok});
          ep = '0;
          if (ok && o == 'h14) ep[c] = 1'b1;
          // R7 strobe for addressed channel only
          chk("R7 cmd_pulse", {62'd0, r_pulse}, ep);
          if (ok) model_wr(c, o, s, d);
          if (ok && o == 'h14) chk("R7 cmd_code", {56'd0, r_code}, {56'd0, d[7:0]});
          acc(0, a, s, 64'd0);
          chk("R1 R2 rd err", {63'd0, r_err}, {63'd0, !ok});
          chk("R3 R5 R6 rd data", r_data, ok ? exp_rd(c, o, s) : 64'd0);
          chk("R7 no pulse on read", {62'd0, r_pulse}, 64'd0);
          for (int k = 0; k < NCH; k++) chk_outs(k);
        end
      end
    end

    // R4 idis: write 0 keeps a set bit, write 1 clears it
    idis_set = 2'b10; @(negedge clk); idis_set = '0; m_ctrl[1][0] = 1;
    acc(1, GB + 128, 2, 64'hABC0);
    m_ctrl[1] = 16'hABC1;
    chk("R4 idis kept", {48'd0, ctrl_o[31:16]}, {48'd0, m_ctrl[1]});
    acc(1, GB + 128, 2, 64'h1235);
    chk("R4 idis cleared", {48'd0, ctrl_o[31:16]}, 64'h1234);

    // R5 busy bit follows busy input
    busy = 2'b10;
    acc(0, GB + 128 + 4, 8, 0);
    chk("R5 status busy", r_data, {stat[127:65], 1'b0});
    acc(0, GB + 4, 8, 0);
    chk("R5 status idle", r_data, {stat[63:1], 1'b1});

    // R8 set wins over same-cycle clear
    acc(1, GB + 'h28, 4, 64'hFFFF_FFFF);
    @(negedge clk);
    err_set[7:0] = 8'h81;
    req_valid = 1; req_write = 1; req_addr = AW'(GB + 'h28); req_size = 4; req_wdata = 64'h0000_00FF;
    @(posedge clk); #1;
    @(negedge clk); req_valid = 0; err_set = '0;
    acc(0, GB + 'h28, 4, 0);
    chk("R8 set wins", r_data, 64'h81);
    acc(1, GB + 'h28, 4, 64'h01);
    acc(0, GB + 'h28, 4, 0);
    chk("R8 w1c", r_data, 64'h80);

    // R6 high then low halves
    acc(1, GB + 'h18, 8, 64'h1111_2222_3333_4444);
    acc(1, GB + 'h1C, 4, 64'hAAAA_BBBB);
    chk("R6 hi keep lo", compl_o[63:0], 64'hAAAA_BBBB_3333_4444);
    acc(1, GB + 'h18, 4, 64'h5555_6666);
    chk("R6 lo keep hi", compl_o[63:0], 64'hAAAA_BBBB_5555_6666);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule